// File: doc/BRIEF.md
# Parallel Display Bus Strobe Generator

This block runs single accesses on an asynchronous 8080-style parallel display bus. A host asks for a command write, a data write or a read. The block then drives the chip-select, write-enable and read-enable strobes, the command/data select line and the data bus. Every strobe edge sits at its own programmed tick offset, measured from the start of the access.

All timing comes from two packed words and a tick-doubling bit. The block checks the programmed edges against a set of ordering rules. If any rule is broken it raises a configuration error and refuses to start an access. A read samples the incoming bus at a programmed access tick and holds the value for the host. Between accesses every strobe sits at its inactive level. A busy flag covers each access from its start to its end.

Top module: `pbus_strobe_gen`

## Requirements
- R1: After reset, busy is low, rdValid is low and rdData is zero. The CS, WE and RE pins sit at their inactive levels, and the command/data pin sits at the data level.
- R2: Edge word fields:
  - chip-select on tick in bits [3:0], off tick in [9:4];
  - write-enable on in [13:10], off in [19:14];
  - read-enable on in [23:20], off in [29:24].
  A strobe is active on ticks t with on <= t < off. Tick 0 is the first clock after the request is accepted.
- R3: Cycle word fields:
  - write cycle length in bits [5:0];
  - read cycle length in [11:6];
  - chip-select idle gap in [17:12];
  - read access tick in [23:18].
  An access lasts max(cycle length for its kind, CS off tick + gap) ticks.
- R4: With tickDouble high each tick lasts two clocks, otherwise one. busy stays high for exactly (access ticks × clocks per tick) clocks.
- R5: A request is accepted only on a clock where busy is low, reqValid is high and cfgErr is low. busy rises in the next cycle.
- R6: polarity[3]=CS, [2]=WE, [1]=RE, [0]=command/data. For CS, WE and RE, bit 1 makes the pin active-high and bit 0 makes it active-low.
- R7: reqKind encoding:
  - 0 is a command write;
  - 1 is a data write;
  - 2 or 3 is a read.
  A command write sets the command/data pin to polarity[0]. A data write or a read sets it to the inverse. The pin keeps that level until the next accepted access.
- R8: Writes pulse WE and never RE. They drive the latched reqData on dbOut with dbOe high for the whole access. Reads pulse RE and never WE, and keep dbOe low.
- R9: A read samples dbIn on the first clock of the access tick. It puts the value on rdData and pulses rdValid for one clock in the following cycle.
- R10: cfgErr is high when any of these rules is broken:
  - WE off > WE on;
  - RE off > RE on;
  - CS off > CS on;
  - CS off >= WE off and CS off >= RE off;
  - write cycle >= WE off;
  - read cycle >= RE off;
  - access tick > RE on.
  While cfgErr is high, requests start no access.
- R11: A request that arrives while busy is high, including in the last busy cycle, is dropped. It changes neither the busy span nor the command/data pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| edgeWord | input | 30 | Packed strobe on/off ticks |
| cycleWord | input | 24 | Packed cycle lengths, CS gap, access tick |
| tickDouble | input | 1 | One tick spans two clocks when high |
| polarity | input | 4 | Pin polarity bits (CS, WE, RE, command/data) |
| reqValid | input | 1 | Access request |
| reqKind | input | 2 | Access kind |
| reqData | input | DW | Write data |
| dbIn | input | DW | Bus data in during reads |
| busy | output | 1 | Access in progress |
| cfgErr | output | 1 | Timing words break an ordering rule |
| csOut | output | 1 | Chip-select pin |
| weOut | output | 1 | Write-enable pin |
| reOut | output | 1 | Read-enable pin |
| a0Out | output | 1 | Command/data select pin |
| dbOut | output | DW | Bus data out |
| dbOe | output | 1 | Bus output enable |
| rdData | output | DW | Captured read data |
| rdValid | output | 1 | One-clock pulse when rdData updates |

## Verification
Two events can land on the same clock: a new request and the end of the current access. A request that meets busy's final cycle must be dropped, not queued or accepted early. The bench raises a command request in that last busy cycle, and again in the middle of an access. It then checks three things: busy falls exactly when the running access should end, busy stays low afterwards, and the command/data pin keeps its data level.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int TICK_W = 7;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_DATA = 2'd1,
    KIND_RD   = 2'd2,
    KIND_RD2  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [3:0] csOn;
    logic [5:0] csOff;
    logic [3:0] weOn;
    logic [5:0] weOff;
    logic [3:0] reOn;
    logic [5:0] reOff;
    logic [5:0] wrCycle;
    logic [5:0] rdCycle;
    logic [5:0] csGap;
    logic [5:0] accTick;
  } timing_t;

  typedef struct packed {
    logic              active;
    logic              load;
    logic              loadCmd;
    logic              isRead;
    logic              capture;
    logic [TICK_W-1:0] tick;
  } strobe_t;
endpackage

// File: rtl/pbus_timing_decode.sv
module pbus_timing_decode
  import pbus_pkg::*;
(
  input  logic [29:0] edgeWord,
  input  logic [23:0] cycleWord,
  output timing_t     tim,
  output logic        cfgErr
);
  always_comb begin
    tim.csOn    = edgeWord[3:0];
    tim.csOff   = edgeWord[9:4];
    tim.weOn    = edgeWord[13:10];
    tim.weOff   = edgeWord[19:14];
    tim.reOn    = edgeWord[23:20];
    tim.reOff   = edgeWord[29:24];
    tim.wrCycle = cycleWord[5:0];
    tim.rdCycle = cycleWord[11:6];
    tim.csGap   = cycleWord[17:12];
    tim.accTick = cycleWord[23:18];
  end

  logic weBad, reBad, csBad, csLate, cycBad, accBad;

  always_comb begin
    weBad  = tim.weOff <= {2'b00, tim.weOn};
    reBad  = tim.reOff <= {2'b00, tim.reOn};
    csBad  = tim.csOff <= {2'b00, tim.csOn};
    csLate = (tim.csOff < tim.weOff) || (tim.csOff < tim.reOff);
    cycBad = (tim.wrCycle < tim.weOff) || (tim.rdCycle < tim.reOff);
    accBad = tim.accTick <= {2'b00, tim.reOn};
    cfgErr = weBad | reBad | csBad | csLate | cycBad | accBad;
  end
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  timing_t    tim,
  input  logic       cfgErr,
  input  logic       tickDouble,
  output strobe_t    ctl,
  output logic       busy
);
  logic              active;
  logic              isRead;
  logic              pre;
  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] cycSel;
  logic [TICK_W-1:0] gapEnd;
  logic [TICK_W-1:0] endTick;
  logic              accept;
  logic              tickDone;

  always_comb begin
    cycSel   = isRead ? {1'b0, tim.rdCycle} : {1'b0, tim.wrCycle};
    gapEnd   = {1'b0, tim.csOff} + {1'b0, tim.csGap};
    endTick  = (cycSel > gapEnd) ? cycSel : gapEnd;
    accept   = reqValid && !active && !cfgErr;
    tickDone = !tickDouble || pre;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      isRead <= 1'b0;
      pre    <= 1'b0;
      tick   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      isRead <= reqKind[1];
      pre    <= 1'b0;
      tick   <= '0;
    end else if (active) begin
      if (tickDone) begin
        pre <= 1'b0;
        if (tick == endTick - 1'b1) active <= 1'b0;
        else                        tick   <= tick + 1'b1;
      end else begin
        pre <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.active  = active;
    ctl.load    = accept;
    ctl.loadCmd = (reqKind == KIND_CMD);
    ctl.isRead  = isRead;
    ctl.capture = active && isRead && !pre && (tick == {1'b0, tim.accTick});
    ctl.tick    = tick;
    busy        = active;
  end

  // R3
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (tick < endTick));

  // R10
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && cfgErr) |=> !active);

  // R4
  slow_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && tickDouble && !pre) |=> (tick == $past(tick)));

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && reqValid && !(tickDone && tick == endTick - 1'b1)) |=> (isRead == $past(isRead)));
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       ctl,
  input  timing_t       tim,
  input  logic [3:0]    polarity,
  input  logic [DW-1:0] reqData,
  input  logic [DW-1:0] dbIn,
  output logic          csOut,
  output logic          weOut,
  output logic          reOut,
  output logic          a0Out,
  output logic [DW-1:0] dbOut,
  output logic          dbOe,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);
  logic          a0Cmd;
  logic [DW-1:0] wrReg;
  logic          csAct, weAct, reAct;

  function automatic logic inWin(input logic [TICK_W-1:0] t,
                                 input logic [TICK_W-1:0] onT,
                                 input logic [TICK_W-1:0] offT);
    return (t >= onT) && (t < offT);
  endfunction

  always_comb begin
    csAct = ctl.active && inWin(ctl.tick, {3'b000, tim.csOn}, {1'b0, tim.csOff});
    weAct = ctl.active && !ctl.isRead && inWin(ctl.tick, {3'b000, tim.weOn}, {1'b0, tim.weOff});
    reAct = ctl.active && ctl.isRead && inWin(ctl.tick, {3'b000, tim.reOn}, {1'b0, tim.reOff});
    csOut = polarity[3] ? csAct : !csAct;
    weOut = polarity[2] ? weAct : !weAct;
    reOut = polarity[1] ? reAct : !reAct;
    a0Out = a0Cmd ? polarity[0] : !polarity[0];
    dbOe  = ctl.active && !ctl.isRead;
    dbOut = wrReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a0Cmd   <= 1'b0;
      wrReg   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.capture;
      if (ctl.load) begin
        a0Cmd <= ctl.loadCmd;
        wrReg <= reqData;
      end
      if (ctl.capture) rdData <= dbIn;
    end
  end

  // R8
  no_we_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.isRead) |-> (weOut == !polarity[2]));

  // R8
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.isRead) |-> !dbOe);

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(ctl.active && ctl.isRead));

  // R1
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (csOut == !polarity[3] && reOut == !polarity[1]));
endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
  import pbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [29:0]   edgeWord,
  input  logic [23:0]   cycleWord,
  input  logic          tickDouble,
  input  logic [3:0]    polarity,
  input  logic          reqValid,
  input  logic [1:0]    reqKind,
  input  logic [DW-1:0] reqData,
  input  logic [DW-1:0] dbIn,
  output logic          busy,
  output logic          cfgErr,
  output logic          csOut,
  output logic          weOut,
  output logic          reOut,
  output logic          a0Out,
  output logic [DW-1:0] dbOut,
  output logic          dbOe,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);
  timing_t tim;
  strobe_t ctl;

  pbus_timing_decode dec_i (
    .edgeWord (edgeWord),
    .cycleWord(cycleWord),
    .tim      (tim),
    .cfgErr   (cfgErr)
  );

  pbus_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .tim       (tim),
    .cfgErr    (cfgErr),
    .tickDouble(tickDouble),
    .ctl       (ctl),
    .busy      (busy)
  );

  pbus_datapath #(.DW(DW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .tim     (tim),
    .polarity(polarity),
    .reqData (reqData),
    .dbIn    (dbIn),
    .csOut   (csOut),
    .weOut   (weOut),
    .reOut   (reOut),
    .a0Out   (a0Out),
    .dbOut   (dbOut),
    .dbOe    (dbOe),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: tb/pbus_strobe_gen_tb_top.sv
module pbus_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [29:0] edgeWord = '0;
  logic [23:0] cycleWord = '0;
  logic        tickDouble = 1'b0;
  logic [3:0]  polarity = 4'h0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [7:0]  reqData = '0;
  logic [7:0]  dbIn = '0;
  logic        busy, cfgErr, csOut, weOut, reOut, a0Out, dbOe, rdValid;
  logic [7:0]  dbOut, rdData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int tCsOn, tCsOff, tWeOn, tWeOff, tReOn, tReOff, tWrCyc, tRdCyc, tGap, tAcc;

  always #4 clk = ~clk;

  pbus_strobe_gen #(.DW(8)) dut_i (
    .clk(clk), .rstN(rstN), .edgeWord(edgeWord), .cycleWord(cycleWord),
    .tickDouble(tickDouble), .polarity(polarity), .reqValid(reqValid),
    .reqKind(reqKind), .reqData(reqData), .dbIn(dbIn), .busy(busy),
    .cfgErr(cfgErr), .csOut(csOut), .weOut(weOut), .reOut(reOut),
    .a0Out(a0Out), .dbOut(dbOut), .dbOe(dbOe), .rdData(rdData),
    .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyCfg();
    edgeWord  = {6'(tReOff), 4'(tReOn), 6'(tWeOff), 4'(tWeOn), 6'(tCsOff), 4'(tCsOn)};
    cycleWord = {6'(tAcc), 6'(tGap), 6'(tRdCyc), 6'(tWrCyc)};
  endtask

  task automatic setBase();
    tCsOn = 1; tCsOff = 6; tWeOn = 2; tWeOff = 4; tReOn = 1; tReOff = 5;
    tWrCyc = 6; tRdCyc = 6; tGap = 1; tAcc = 3;
  endtask

  function automatic int endTicks(input int kind);
    int cyc = (kind >= 2) ? tRdCyc : tWrCyc;
    return (cyc > tCsOff + tGap) ? cyc : tCsOff + tGap;
  endfunction

  // Full access with per-clock comparison of all pins (R2 R3 R5 R6 R7 R8 R9)
  task automatic runAccess(input int div, input int pol, input int kind, input logic [7:0] data);
    int total, busyCnt;
    bit isRd;
    @(negedge clk);
    applyCfg();
    tickDouble = (div == 2);
    polarity = 4'(pol);
    reqKind = 2'(kind);
    reqData = data;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    isRd = (kind >= 2);
    total = endTicks(kind) * div;
    busyCnt = 0;
    for (int k = 0; k < total + 2; k++) begin
      int t = k / div;
      bit act = (k < total);
      bit cE = act && t >= tCsOn && t < tCsOff;
      bit wE = act && !isRd && t >= tWeOn && t < tWeOff;
      bit rE = act && isRd && t >= tReOn && t < tReOff;
      bit a0E = (kind == 0) ? pol[0] : !pol[0];
      bit rvE = isRd && (k == tAcc * div + 1);
      logic [6:0] expV, actV;
      expV = {(pol[3] ? cE : !cE), (pol[2] ? wE : !wE), (pol[1] ? rE : !rE),
              a0E, act, act && !isRd, rvE};
      actV = {csOut, weOut, reOut, a0Out, busy, dbOe, rdValid};
      check(actV == expV, "R2/R3/R5/R6/R7/R8 pins", int'(actV), int'(expV));
      if (act && !isRd) check(dbOut == data, "R8 write data", dbOut, data);
      if (busy) busyCnt++;
      dbIn = 8'(8'h40 + k);
      @(negedge clk);
    end
    // R4
    check(busyCnt == total, "R4 busy length", busyCnt, total);
    // R9
    if (isRd) check(rdData == 8'(8'h40 + tAcc * div), "R9 read capture", rdData, 8'(8'h40 + tAcc * div));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    setBase();
    applyCfg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check({busy, rdValid, csOut, weOut, reOut, a0Out} == 6'b001111, "R1 reset pins",
          {busy, rdValid, csOut, weOut, reOut, a0Out}, 6'b001111);
    check(rdData == 8'h00, "R1 reset rdData", rdData, 0);

    // Sweep of timings, tick lengths, kinds and polarities
    for (int d = 1; d <= 2; d++)
      for (int c = 0; c < 6; c++)
        for (int kd = 0; kd < 4; kd++) begin
          tCsOn = c % 2; tWeOn = tCsOn + c % 3; tWeOff = tWeOn + 1 + c % 2;
          tReOn = c % 2; tReOff = tReOn + 2 + c % 3;
          tCsOff = ((tWeOff > tReOff) ? tWeOff : tReOff) + c % 2;
          tWrCyc = tWeOff + c % 4; tRdCyc = tReOff + c % 3;
          tGap = c % 3; tAcc = tReOn + 1 + (c % 2);
          runAccess(d, (c * 5 + d * 3 + kd) % 16, kd, 8'(8'h3C + c * 17 + kd));
        end

    // R10 ordering violations
    for (int b = 0; b < 7; b++) begin
      logic a0Before;
      setBase();
      case (b)
        0: tWeOff = tWeOn;
        1: tReOff = tReOn;
        2: tCsOff = tCsOn;
        3: tCsOff = 4;
        4: tWrCyc = 3;
        5: tRdCyc = 4;
        default: tAcc = tReOn;
      endcase
      @(negedge clk);
      applyCfg();
      polarity = 4'h0;
      tickDouble = 1'b0;
      #1;
      check(cfgErr == 1'b1, "R10 cfgErr flag", cfgErr, 1);
      a0Before = a0Out;
      reqKind = (a0Before == 1'b1) ? 2'd0 : 2'd1;
      reqValid = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check({busy, csOut, a0Out} == {1'b0, 1'b1, a0Before}, "R10 no access",
              {busy, csOut, a0Out}, {1'b0, 1'b1, a0Before});
      end
      reqValid = 1'b0;
    end
    setBase();
    @(negedge clk);
    applyCfg();
    #1;
    check(cfgErr == 1'b0, "R10 base config valid", cfgErr, 0);

    // R11 requests during busy, including its final cycle
    begin
      int total, busyCnt;
      polarity = 4'h0;
      tickDouble = 1'b0;
      reqKind = 2'd1;
      reqData = 8'hA5;
      reqValid = 1'b1;
      @(negedge clk);
      total = endTicks(1);
      busyCnt = 0;
      for (int k = 0; k < total + 2; k++) begin
        check(busy == (k < total), "R11 busy span", busy, k < total);
        check(a0Out == 1'b1, "R11 a0 kept at data level", a0Out, 1);
        if (busy) busyCnt++;
        reqKind = 2'd0;
        reqValid = (k == 2) || (k == total - 1);
        @(negedge clk);
      end
      reqValid = 1'b0;
      check(busyCnt == total, "R11 busy length", busyCnt, total);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule